// File: doc/BRIEF.md
# Serial Switch Control Register

This block drives the on/off enables of a bank of switch channels from a serial bit stream. Bits arrive on `sdi` and are qualified by a slow serial strobe, `shift_clk`. The block samples that strobe with the system clock `clk`. Each detected low-to-high transition of the strobe pushes one bit into a channel-wide shift register. A separate active-low load control, `load_n`, decides whether the switch outputs follow the shift register or freeze. While `load_n` is low, the outputs track the register at every clock boundary. When `load_n` returns high, they keep the last tracked value, and further shifting leaves them alone.

A clear input, `clr`, turns every channel off at once, without waiting for a clock edge. It does not touch the shift register. The last shift stage is presented on `sdo`. Several blocks can therefore be chained, each one's `sdo` feeding the next one's `sdi`, and they share one strobe and one load control. The serial path has no back-pressure and no valid/ready pair. Every detected strobe rise is accepted, so the sender paces the stream by how it toggles the strobe. All other pins are plain control levels.

Top module: `serial_switch_ctrl`

## Requirements
- R1: On each `clk` edge at which `shift_clk` is sampled high after being sampled low on the previous edge, stage 0 takes `sdi` and every stage k (k >= 1) takes stage k-1. Holding `shift_clk` high or low causes no further shifts.
- R2: While `load_n` is sampled low on a `clk` edge, `sw_en` shows the shift register contents as they stand after that edge.
- R3: While `load_n` is high, `sw_en` keeps the value captured at the last edge on which `load_n` was low, and shifting does not change it.
- R4: While `clr` is high, `sw_en` is all zeros at once, with no clock edge needed, whatever `load_n`, `shift_clk` and `sdi` do.
- R5: `clr` does not alter the shift register. After `clr` falls with `load_n` low, `sw_en` shows the register after the next `clk` edge. After `clr` falls with `load_n` high, `sw_en` stays all zeros until the next load.
- R6: `sdo` equals shift stage CH-1 at all times.
- R7: `sw_en[n] = 1` turns channel n on and 0 turns it off, and the channels are independent. The first of CH consecutive shifted bits ends up controlling channel CH-1.
- R8: After reset, the shift register and `sw_en` are all zeros and `sdo` is 0.
- R9: In a chain of two blocks (`sdo` of the first to `sdi` of the second), 2*CH strobe rises followed by one load pulse deliver the first CH bits to the far block and the last CH bits to the near block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Serial strobe; a sampled rise shifts one bit |
| sdi | input | 1 | Serial data in |
| load_n | input | 1 | Active-low load; outputs track the register while low |
| clr | input | 1 | Asynchronous clear of all switch enables, active high |
| sdo | output | 1 | Last shift stage, for chaining |
| sw_en | output | CH | Per-channel switch enable, 1 = on |

## Verification
The bench builds two instances with the default CH = 8 and wires them as a chain, so every serial sequence also exercises the stage-to-stage hand-off across the block boundary. Eight channels keep a full-register reload and the 16-strobe chained load short. This brings the channel-order corner, the clear-then-release paths with both load levels and a long random mix of strobes, load levels and clears within reach in a few thousand cycles.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  // default channel count of the switch bank
  localparam int DEF_CH = 8;

  // a strobe rise is seen when the current sample is high and the previous low
  function automatic logic strobe_rise(input logic now_s, input logic prev_s);
    return now_s & ~prev_s;
  endfunction
endpackage

// File: rtl/swctl_shift.sv
module swctl_shift #(
  parameter int CH = swctl_pkg::DEF_CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_clk,
  input  logic          sdi,
  output logic [CH-1:0] sr_q,
  output logic [CH-1:0] sr_d
);
  logic strobe_prev;
  logic adv;

  // previous strobe sample; follows the pin during reset too
  always_ff @(posedge clk) begin
    strobe_prev <= shift_clk;
  end

  assign adv = swctl_pkg::strobe_rise(shift_clk, strobe_prev);

  // next register value; stage 0 takes the serial input (R1)
  always_comb begin
    sr_d = sr_q;
    if (adv) begin
      sr_d = {sr_q[CH-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end
endmodule

// File: rtl/swctl_hold_cell.sv
module swctl_hold_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic d,
  output logic q
);
  // one channel: loads while enabled, freezes otherwise, cleared asynchronously
  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (clr) begin
      q <= 1'b0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl #(
  parameter int CH = swctl_pkg::DEF_CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_clk,
  input  logic          sdi,
  input  logic          load_n,
  input  logic          clr,
  output logic          sdo,
  output logic [CH-1:0] sw_en
);
  localparam int LAST = CH - 1;

  logic [CH-1:0] sr_q;
  logic [CH-1:0] sr_d;
  logic          load_en;

  swctl_shift #(.CH(CH)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_clk (shift_clk),
    .sdi       (sdi),
    .sr_q      (sr_q),
    .sr_d      (sr_d)
  );

  assign load_en = ~load_n;

  // loading the post-edge value makes the outputs match the register at each edge (R2)
  for (genvar ch = 0; ch < CH; ch++) begin : g_chan
    swctl_hold_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .load  (load_en),
      .d     (sr_d[ch]),
      .q     (sw_en[ch])
    );
  end

  assign sdo = sr_q[LAST];  // R6
endmodule

// File: rtl/swctl_chk.sv
module swctl_chk #(
  parameter int CH = swctl_pkg::DEF_CH
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shift_clk,
  input logic          load_n,
  input logic          clr,
  input logic          sdo,
  input logic [CH-1:0] sw_en
);
  AST_CLR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (sw_en == '0)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_n) && !clr && !$past(clr)) |-> $stable(sw_en)); // R3

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(shift_clk) |=> $stable(sdo)); // R1

  AST_TRACK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_n) && !clr && !$past(clr)) |-> (sw_en[CH-1] == sdo)); // R2
endmodule

bind serial_switch_ctrl swctl_chk #(.CH(CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_clk (shift_clk),
  .load_n    (load_n),
  .clr       (clr),
  .sdo       (sdo),
  .sw_en     (sw_en)
);

// File: tb/serial_switch_ctrl_tb.sv
module serial_switch_ctrl_tb;
  localparam int CH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_clk = 1'b0;
  logic sdi = 1'b0;
  logic load_n = 1'b1;
  logic clr = 1'b0;
  logic sdo1, sdo2;
  logic [CH-1:0] sw1, sw2;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // bench model of both chained devices
  logic [CH-1:0] m_sr1 = '0, m_sr2 = '0, m_lat1 = '0, m_lat2 = '0;

  always #10 clk = ~clk;  // 50 MHz

  serial_switch_ctrl #(.CH(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .sdi(sdi),
    .load_n(load_n), .clr(clr), .sdo(sdo1), .sw_en(sw1));

  serial_switch_ctrl #(.CH(CH)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .sdi(sdo1),
    .load_n(load_n), .clr(clr), .sdo(sdo2), .sw_en(sw2));

  task automatic chk(input string tag, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [CH-1:0] shifted(input logic [CH-1:0] r, input logic b);
    return {r[CH-2:0], b};
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " sw_en dev1"}, sw1, clr ? '0 : m_lat1);
    chk({tag, " sw_en dev2"}, sw2, clr ? '0 : m_lat2);
    chk({tag, " sdo dev1 R6"}, {{(CH-1){1'b0}}, sdo1}, {{(CH-1){1'b0}}, m_sr1[CH-1]});
    chk({tag, " sdo dev2 R6"}, {{(CH-1){1'b0}}, sdo2}, {{(CH-1){1'b0}}, m_sr2[CH-1]});
  endtask

  // one strobe rise spanning two clk edges; the model shifts once (R1)
  task automatic shift_bit(input logic b);
    sdi = b;
    shift_clk = 1'b1;
    @(negedge clk);
    shift_clk = 1'b0;
    @(negedge clk);
    m_sr2 = shifted(m_sr2, m_sr1[CH-1]);
    m_sr1 = shifted(m_sr1, b);
    if (!load_n && !clr) begin
      m_lat1 = m_sr1;
      m_lat2 = m_sr2;
    end
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    @(negedge clk);
    if (!clr) begin
      m_lat1 = m_sr1;
      m_lat2 = m_sr2;
    end
  endtask

  task automatic set_load(input logic v);
    load_n = v;
    @(negedge clk);
    if (!load_n && !clr) begin
      m_lat1 = m_sr1;
      m_lat2 = m_sr2;
    end
  endtask

  task automatic clr_pulse();
    clr = 1'b1;
    #3;
    chk("R4 clear without edge", sw1, '0);
    m_lat1 = '0;
    m_lat2 = '0;
    @(negedge clk);
    check_all("R4 during clear");
    clr = 1'b0;
    @(negedge clk);
    if (!load_n) begin
      m_lat1 = m_sr1;
      m_lat2 = m_sr2;
    end
    check_all("R5 after clear release");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [CH-1:0] snap;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset sw_en", sw1, '0);
    chk("R8 reset sdo", {{(CH-1){1'b0}}, sdo1}, '0);

    // R7: first bit of eight lands on channel 7
    shift_bit(1'b1);
    for (int i = 0; i < CH - 1; i++) shift_bit(1'b0);
    chk("R3 no change while load high", sw1, '0);
    pulse_load();
    chk("R7 first bit on channel 7", sw1, 8'h80);
    check_all("R7 model");

    // R3: shifting with load high leaves outputs alone
    snap = sw1;
    for (int i = 0; i < 5; i++) shift_bit(1'($urandom));
    chk("R3 hold across shifts", sw1, snap);
    check_all("R3 model");

    // R2: transparent while load low
    set_load(1'b0);
    check_all("R2 enter load");
    for (int i = 0; i < CH; i++) begin
      shift_bit(1'($urandom));
      chk("R2 tracks register", sw1, m_sr1);
    end
    set_load(1'b1);
    snap = sw1;
    shift_bit(~m_sr1[0]);
    chk("R3 frozen after load rises", sw1, snap);

    // R4/R5: clear with load high keeps outputs off, register intact
    clr_pulse();
    chk("R5 off after release with load high", sw1, '0);
    pulse_load();
    chk("R5 register survived clear", sw1, m_sr1);

    // R4/R5: clear with load low, shifting during clear
    set_load(1'b0);
    clr = 1'b1;
    #3;
    chk("R4 async clear with load low", sw1, '0);
    @(negedge clk);
    m_lat1 = '0;
    m_lat2 = '0;
    shift_bit(1'b1);
    chk("R4 clear overrides load and shift", sw1, '0);
    clr = 1'b0;
    @(negedge clk);
    m_lat1 = m_sr1;
    m_lat2 = m_sr2;
    chk("R5 follows register after release", sw1, m_sr1);
    set_load(1'b1);

    // R9: two-device chain, 16 strobes then one load pulse
    for (int i = 15; i >= 0; i--) shift_bit(16'hA53C >> i);
    pulse_load();
    chk("R9 far device", sw2, 8'hA5);
    chk("R9 near device", sw1, 8'h3C);
    check_all("R9 model");

    // random mix against the model (R1 R2 R3 R4 R5 R6)
    for (int n = 0; n < 400; n++) begin
      int unsigned op;
      op = $urandom_range(0, 99);
      if (op < 60) shift_bit(1'($urandom));
      else if (op < 75) pulse_load();
      else if (op < 90) set_load(~load_n);
      else clr_pulse();
      check_all("R1 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule